// File: doc/BRIEF.md
# Programmable One-Shot / Periodic Down-Count Timer Channel

This block is one down-counting timer channel. It advances only in cycles where the tick-enable input is high; in a typical system that input pulses at 1 MHz. Software programs the channel through a small register port. A control word holds an enable flag, a periodic-mode flag and a 29-bit load value in one 32-bit word. The channel counts from the load value down to zero. The tick that arrives while the count is zero is the expiry, so a load value of N gives an expiry on tick N+1. On expiry the channel raises a level interrupt. It then either reloads and keeps running (periodic) or stops (one-shot).

A controller sequences the channel through three states: `ST_IDLE`, `ST_ONESHOT` and `ST_PERIODIC`. Transitions:
- a control write with enable 0 goes from any state to `ST_IDLE`;
- a control write with enable 1 and periodic 0 goes to `ST_ONESHOT`;
- a control write with enable 1 and periodic 1 goes to `ST_PERIODIC`;
- an expiry in `ST_ONESHOT` returns to `ST_IDLE`;
- an expiry in `ST_PERIODIC` stays in `ST_PERIODIC`.

The interrupt stays latched until software writes a one to the clear bit of the status register.

Top module: `tick_timer_chan`

## Requirements
- R1: After reset `irq` is 0, and both registers read 0x00000000.
- R2: A write to offset 0x0 takes bit 31 as enable, bit 30 as periodic and bits 28:0 as the load value. The count restarts from the load value in the following cycle, even while the channel is running. Reading offset 0x0 returns {enable, periodic, 1'b0, load}, so bit 29 always reads 0.
- R3: While enabled, each cycle with `tick` high lowers the count by one. A tick while the count is 0 is an expiry, so the first expiry comes on tick load+1. A load of 0 expires on the first tick.
- R4: In periodic mode an expiry reloads the count with the load value, and the channel keeps running.
- R5: In one-shot mode an expiry stops the channel. The enable bit then reads back 0, and the count holds at 0 under further ticks.
- R6: A control write with bit 31 clear stops the channel. Further ticks then change neither the count nor `irq`.
- R7: `irq` rises in the cycle after an expiry and stays high until it is cleared.
- R8: A write to offset 0x4 with bit 30 set clears `irq` in the next cycle. Such a write with bit 30 clear leaves `irq` as it is.
- R9: If an expiry and a clear write fall in the same cycle, `irq` stays high.
- R10: Reading offset 0x4 returns the pending interrupt in bit 30 and the current count in bits 28:0, with all other bits 0. Any offset other than 0x0 and 0x4 reads 0.
- R11: If a control write and a tick fall in the same cycle, the write wins. The count takes the new load value, and no decrement or expiry happens.
- R12: In cycles with `tick` low and no control write, the count does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable pulse; one count step per high cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Byte offset: 0x0 control, 0x4 status/clear |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt, latched until cleared |

## Verification
Two pairs of functions can land in the same clock edge.

- **Expiry and interrupt clear.** The bench runs a periodic channel down to zero. It then drives a clear write together with the expiring tick. It judges the result by `irq` staying high and by the status register showing the reloaded count.
- **Control write and tick.** The bench drives both in one cycle. The count must equal the new load value with no decrement applied.

The scoreboard holds the expected value for each of these reads.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ONESHOT  = 2'd1,
        ST_PERIODIC = 2'd2
    } tmr_state_e;
endpackage

// File: rtl/tick_timer_fsm.sv
module tick_timer_fsm
    import tick_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic       wr_enable,
    input  logic       wr_periodic,
    input  logic       tick,
    input  logic       cnt_zero,
    output tmr_state_e state,
    output logic       dec,
    output logic       expire,
    output logic       reload
);
    tmr_state_e state_q, state_d;
    logic       running;

    // running channel sees a tick while no control write overrides it
    assign running = (state_q != ST_IDLE);
    assign expire  = running && tick && !ctrl_wr && cnt_zero;

    always_comb begin
        state_d = state_q;
        if (ctrl_wr) begin
            if (!wr_enable)       state_d = ST_IDLE;
            else if (wr_periodic) state_d = ST_PERIODIC;
            else                  state_d = ST_ONESHOT;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ONESHOT:  if (expire) state_d = ST_IDLE;
                ST_PERIODIC: state_d = ST_PERIODIC;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        dec    = 1'b0;
        reload = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_ONESHOT:  dec = tick && !ctrl_wr && !cnt_zero;
            ST_PERIODIC: begin
                dec    = tick && !ctrl_wr && !cnt_zero;
                reload = expire;
            end
            default:     ;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/tick_timer_counter.sv
module tick_timer_counter #(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_now,
    input  logic [CNT_W-1:0] load_val,
    input  logic             reload,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (load_now) cnt_q <= load_val;
        else if (reload)   cnt_q <= reload_val;
        else if (dec)      cnt_q <= cnt_q - CNT_W'(1);
    end

    assign count = cnt_q;
    assign zero  = (cnt_q == '0);
endmodule

// File: rtl/tick_timer_irq.sv
module tick_timer_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic irq
);
    logic pend_q;

    // a new expiry beats a clear arriving in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)   pend_q <= 1'b0;
        else if (set) pend_q <= 1'b1;
        else if (clr) pend_q <= 1'b0;
    end

    assign irq = pend_q;
endmodule

// File: rtl/tick_timer_chan.sv
module tick_timer_chan
    import tick_timer_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 29,
    parameter int ADDR_W   = 3,
    parameter int EN_BIT   = 31,
    parameter int PER_BIT  = 30,
    parameter int CLR_BIT  = 30,
    parameter int CTRL_OFS = 0,
    parameter int STAT_OFS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

    logic             ctrl_wr, clr_wr;
    logic [CNT_W-1:0] load_q, count;
    logic             per_q, cnt_zero, dec, expire, reload;
    tmr_state_e       state;

    assign ctrl_wr = bus_wr && (bus_addr == CTRL_A);
    assign clr_wr  = bus_wr && (bus_addr == STAT_A) && bus_wdata[CLR_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= '0;
            per_q  <= 1'b0;
        end else if (ctrl_wr) begin
            load_q <= bus_wdata[CNT_W-1:0];
            per_q  <= bus_wdata[PER_BIT];
        end
    end

    tick_timer_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (ctrl_wr),
        .wr_enable   (bus_wdata[EN_BIT]),
        .wr_periodic (bus_wdata[PER_BIT]),
        .tick        (tick),
        .cnt_zero    (cnt_zero),
        .state       (state),
        .dec         (dec),
        .expire      (expire),
        .reload      (reload)
    );

    tick_timer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_now   (ctrl_wr),
        .load_val   (bus_wdata[CNT_W-1:0]),
        .reload     (reload),
        .reload_val (load_q),
        .dec        (dec),
        .count      (count),
        .zero       (cnt_zero)
    );

    tick_timer_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (expire),
        .clr   (clr_wr),
        .irq   (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_A) begin
            bus_rdata[CNT_W-1:0] = load_q;
            bus_rdata[PER_BIT]   = per_q;
            bus_rdata[EN_BIT]    = (state != ST_IDLE);
        end else if (bus_addr == STAT_A) begin
            bus_rdata[CNT_W-1:0] = count;
            bus_rdata[CLR_BIT]   = irq;
        end
    end
endmodule

// File: rtl/tick_timer_chan_chk.sv
module tick_timer_chan_chk
    import tick_timer_pkg::*;
#(
    parameter int CNT_W  = 29,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              ctrl_wr,
    input logic              clr_wr,
    input logic [CNT_W-1:0]  wr_load,
    input logic              irq,
    input logic              expire,
    input tmr_state_e        state,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  load_q
);
    AST_EXPIRE_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq); // R7
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_wr) |=> irq); // R7
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !expire) |=> !irq); // R8
    AST_EXPIRY_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && expire) |=> irq); // R9
    AST_ONESHOT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && state == ST_ONESHOT) |=> (state == ST_IDLE)); // R5
    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && state == ST_PERIODIC) |=> (count == $past(load_q))); // R4
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (count == $past(wr_load))); // R11
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ctrl_wr) |=> $stable(count)); // R12
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !ctrl_wr) |=> ($stable(count) && !expire)); // R6
endmodule

bind tick_timer_chan tick_timer_chan_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .ctrl_wr (ctrl_wr),
    .clr_wr  (clr_wr),
    .wr_load (bus_wdata[CNT_W-1:0]),
    .irq     (irq),
    .expire  (expire),
    .state   (state),
    .count   (count),
    .load_q  (load_q)
);

// File: tb/tick_timer_chan_test.sv
module tick_timer_chan_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } exp_item_t;

    exp_item_t exp_q[$];
    event      sample_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_timer_chan uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // monitor: pops expectations and compares with what the design shows
    initial begin
        forever begin
            @(sample_ev);
            #1;
            while (exp_q.size() > 0) begin
                exp_item_t it;
                logic [31:0] act;
                it = exp_q.pop_front();
                act = it.is_irq ? {31'd0, irq} : bus_rdata;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic expect_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
        exp_item_t it;
        @(negedge clk);
        bus_addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        -> sample_ev;
        #2;
    endtask

    task automatic expect_irq(input logic e, input string tag);
        exp_item_t it;
        @(negedge clk);
        it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
        exp_q.push_back(it);
        -> sample_ev;
        #2;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr_tick(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick = 1'b0;
    endtask

    task automatic pulses(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_irq(1'b0, "R1 irq after reset");
        expect_rd(3'h0, 32'h0, "R1 control after reset");
        expect_rd(3'h4, 32'h0, "R1 status after reset");

        // one-shot, load 3
        wr(3'h0, 32'h8000_0003);
        expect_rd(3'h0, 32'h8000_0003, "R2 control readback");
        expect_rd(3'h4, 32'h0000_0003, "R10 status shows load");
        pulses(3);
        expect_rd(3'h4, 32'h0000_0000, "R3 count at zero after load ticks");
        expect_irq(1'b0, "R3 no expiry before tick load+1");
        pulses(1);
        expect_irq(1'b1, "R7 irq on expiry");
        expect_rd(3'h4, 32'h4000_0000, "R10 status pending bit");
        expect_rd(3'h0, 32'h0000_0003, "R5 enable cleared after one-shot");
        pulses(4);
        expect_rd(3'h4, 32'h4000_0000, "R5 one-shot count holds");
        wr(3'h4, 32'h0000_0000);
        expect_irq(1'b1, "R8 clear with bit30 low ignored");
        wr(3'h4, 32'h4000_0000);
        expect_irq(1'b0, "R8 clear with bit30 set");
        expect_rd(3'h2, 32'h0, "R10 unmapped offset reads zero");

        // load 0 expires on first tick
        wr(3'h0, 32'h8000_0000);
        pulses(1);
        expect_irq(1'b1, "R3 load 0 fires after one tick");
        wr(3'h4, 32'h4000_0000);

        // periodic, load 2
        wr(3'h0, 32'hC000_0002);
        pulses(3);
        expect_irq(1'b1, "R4 periodic first expiry");
        expect_rd(3'h4, 32'h4000_0002, "R4 periodic reload");
        expect_rd(3'h0, 32'hC000_0002, "R4 still enabled");
        wr(3'h4, 32'h4000_0000);
        pulses(2);
        expect_rd(3'h4, 32'h0000_0000, "R4 counting down again");
        wr_tick(3'h4, 32'h4000_0000);
        expect_irq(1'b1, "R9 expiry beats clear");
        expect_rd(3'h4, 32'h4000_0002, "R9 reload with clear same cycle");
        wr(3'h4, 32'h4000_0000);

        // restart while running
        pulses(1);
        expect_rd(3'h4, 32'h0000_0001, "R3 one decrement");
        wr(3'h0, 32'hC000_0005);
        expect_rd(3'h4, 32'h0000_0005, "R2 restart from new load");
        wr_tick(3'h0, 32'hC000_0004);
        expect_rd(3'h4, 32'h0000_0004, "R11 write wins over tick");
        expect_irq(1'b0, "R11 no expiry on write cycle");
        repeat (5) @(negedge clk);
        expect_rd(3'h4, 32'h0000_0004, "R12 no tick no change");

        // stop
        wr(3'h0, 32'h4000_0007);
        expect_rd(3'h0, 32'h4000_0007, "R6 disabled readback");
        pulses(20);
        expect_rd(3'h4, 32'h0000_0007, "R6 stopped count frozen");
        expect_irq(1'b0, "R6 stopped no irq");

        // widest load, bit 29 dropped
        wr(3'h0, 32'hBFFF_FFFF);
        expect_rd(3'h0, 32'h9FFF_FFFF, "R2 bit29 reads zero");
        expect_rd(3'h4, 32'h1FFF_FFFF, "R2 max load");
        pulses(1);
        expect_rd(3'h4, 32'h1FFF_FFFE, "R3 max load decrements");
        wr(3'h0, 32'h0000_0000);
        expect_rd(3'h0, 32'h0000_0000, "R6 zero word stops");
        pulses(3);
        expect_rd(3'h4, 32'h0000_0000, "R6 zero word no expiry");
        expect_irq(1'b0, "R6 zero word irq low");

        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule